// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in and returns the sum and the carry-out. The operands are cut into four slices of four bits. Each slice forms a generate and a propagate term for every bit. From these it derives the carry into each of its own bits, and it also exports a single slice-level propagate and generate pair.

A second lookahead unit, built the same way as the slice units, takes the four slice pairs and the carry-in. It computes the carry entering each slice and the final carry-out. No carry ripples from one slice into the next, so the longest path is two lookahead evaluations plus the sum XOR. Slice width and slice count are parameters, and the default is four slices of four bits.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, with the operands treated as unsigned.
- R2: `carry_out` equals bit 16 of the 17-bit result `op_a + op_b + carry_in`. For example, 0xFFFF + 0xFFFF + 1 gives `carry_out` = 1 and `sum_out` = 0xFFFF.
- R3: `carry_in` has weight one. With both operands zero, `carry_in` = 1 gives `sum_out` = 0x0001 and `carry_out` = 0. For any operands, raising `carry_in` adds exactly one to the 17-bit result.
- R4: When every bit position propagates, the carry-in passes through all slices. Every bit position propagates when `op_a ^ op_b` = 0xFFFF, which implies no position has both bits set. In that case `carry_in` = 0 gives `sum_out` = 0xFFFF and `carry_out` = 0. `carry_in` = 1 gives `sum_out` = 0x0000 and `carry_out` = 1.
- R5: A carry generated in slice k, which covers bits 4k to 4k+3, enters bit 4(k+1) of the next slice. For example, 0x000F + 0x0001 gives 0x0010, and 0x0F00 + 0x0100 gives 0x1000. With the operands 0xFFF0 and 0x0010, the carry leaves slice 1 and reaches `carry_out` through the propagating slices 2 and 3, giving `sum_out` = 0x0000 and `carry_out` = 1.
- R6: Inside each lookahead unit, the carry entering bit i+1 equals gi OR (pi AND ci). A unit whose inputs all propagate passes its carry-in to its carry-out. A unit with its group generate set produces a carry-out of 1.
- R7: Both operands zero with `carry_in` = 0 give `sum_out` = 0 and `carry_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The assertions are immediate checks evaluated on the combinational nets. They are valid only when `op_a`, `op_b` and `carry_in` all carry known values, so every check is guarded against unknown inputs. The bench always drives complete, known operand and carry values before it samples any output, so no check ever sees a partly driven input. The bench drives the inputs on the falling clock edge and reads the outputs one time unit later, after the combinational logic has settled.

// File: rtl/cla_pkg.sv
package cla_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Widest vector any lookahead unit may receive
    localparam int LA_MAX = 32;

    // Propagate/generate pair exported by one slice
    typedef struct packed {
        logic prop;
        logic gen;
    } grp_pg_t;

    // Carry into position n, written as a flat sum of products:
    // OR over j<n of g[j] AND p[j+1..n-1], plus cin AND p[0..n-1].
    function automatic logic la_carry(input logic [LA_MAX-1:0] p,
                                      input logic [LA_MAX-1:0] g,
                                      input logic cin,
                                      input int n);
        logic res;
        logic term;
        res = 1'b0;
        for (int j = 0; j < LA_MAX; j++) begin
            if (j < n) begin
                term = g[j];
                for (int k = 0; k < LA_MAX; k++) begin
                    if (k > j && k < n) term = term & p[k];
                end
                res = res | term;
            end
        end
        term = cin;
        for (int k = 0; k < LA_MAX; k++) begin
            if (k < n) term = term & p[k];
        end
        return res | term;
    endfunction
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o,
    output logic [W-1:0] g_o
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign g_o[i] = a_i[i] & b_i[i];
        assign p_o[i] = a_i[i] ^ b_i[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] g_i,
    input  logic         c_i,
    output logic [W-1:0] c_o,     // carry into each position
    output logic         cout_o,  // carry out of the top position
    output grp_pg_t      grp_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LA_MAX-1:0] p_ext;
    logic [LA_MAX-1:0] g_ext;

    assign p_ext = LA_MAX'(p_i);
    assign g_ext = LA_MAX'(g_i);

    always_comb begin
        for (int i = 0; i < W; i++) begin
            c_o[i] = la_carry(p_ext, g_ext, c_i, i);
        end
        cout_o     = la_carry(p_ext, g_ext, c_i, W);
        grp_o.prop = &p_i;
        grp_o.gen  = la_carry(p_ext, g_ext, 1'b0, W);
    end

    always_comb begin
        if (!$isunknown({p_i, g_i, c_i})) begin
            for (int i = 0; i + 1 < W; i++) begin
                // R6
                carry_step_chk: assert (c_o[i+1] == (g_i[i] | (p_i[i] & c_o[i])));
            end
            // R6
            top_step_chk: assert (cout_o == (g_i[W-1] | (p_i[W-1] & c_o[W-1])));
            // R6
            full_prop_chk: assert (!grp_o.prop || (cout_o == c_i));
            // R6
            grp_gen_chk: assert (!grp_o.gen || cout_o);
        end
    end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output grp_pg_t      grp_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] p_w;
    logic [W-1:0] g_w;
    logic [W-1:0] c_w;
    logic         cout_w;

    cla_bit_pg #(.W(W)) pg_i (
        .a_i (a_i),
        .b_i (b_i),
        .p_o (p_w),
        .g_o (g_w)
    );

    cla_lookahead #(.W(W)) la_i (
        .p_i    (p_w),
        .g_i    (g_w),
        .c_i    (c_i),
        .c_o    (c_w),
        .cout_o (cout_w),
        .grp_o  (grp_o)
    );

    assign s_o = p_w ^ c_w;

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i})) begin
            // R5
            slice_sum_chk: assert ({cout_w, s_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)));
            // R5
            slice_cout_chk: assert (cout_w == (grp_o.gen | (grp_o.prop & c_i)));
        end
    end
endmodule

// File: rtl/cla_two_level_adder.sv
module cla_two_level_adder
    import cla_pkg::*;
#(
    parameter int GRP_W = 4,
    parameter int N_GRP = 4,
    localparam int DATA_W = GRP_W * N_GRP
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    timeunit 1ns;
    timeprecision 1ps;

    grp_pg_t            grp_w [N_GRP];
    logic [N_GRP-1:0]   grp_p;
    logic [N_GRP-1:0]   grp_g;
    logic [N_GRP-1:0]   grp_c;
    grp_pg_t            top_pg;

    for (genvar k = 0; k < N_GRP; k++) begin : g_slice
        cla_slice #(.W(GRP_W)) slice_i (
            .a_i   (op_a[k*GRP_W +: GRP_W]),
            .b_i   (op_b[k*GRP_W +: GRP_W]),
            .c_i   (grp_c[k]),
            .s_o   (sum_out[k*GRP_W +: GRP_W]),
            .grp_o (grp_w[k])
        );
        assign grp_p[k] = grp_w[k].prop;
        assign grp_g[k] = grp_w[k].gen;
    end

    // Second level: slice carries from slice-level P/G
    cla_lookahead #(.W(N_GRP)) top_la_i (
        .p_i    (grp_p),
        .g_i    (grp_g),
        .c_i    (carry_in),
        .c_o    (grp_c),
        .cout_o (carry_out),
        .grp_o  (top_pg)
    );

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            // R1
            sum_ref_chk: assert (sum_out == DATA_W'(op_a + op_b + DATA_W'(carry_in)));
            // R2
            cout_ref_chk: assert ({carry_out, sum_out} ==
                                  ({1'b0, op_a} + {1'b0, op_b} + (DATA_W+1)'(carry_in)));
            // R4
            whole_prop_chk: assert (!top_pg.prop || (carry_out == carry_in));
            // R2
            whole_gen_chk: assert (!top_pg.gen || carry_out);
        end
    end
endmodule

// File: tb/cla_two_level_adder_tb.sv
module cla_two_level_adder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cla_two_level_adder dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors = errors + 1;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic apply_check(input logic [15:0] a, input logic [15:0] b,
                               input logic cin, input string req);
        logic [16:0] exp_v;
        @(negedge clk);
        op_a = a;
        op_b = b;
        carry_in = cin;
        #1;
        exp_v = {1'b0, a} + {1'b0, b} + 17'(cin);
        checks++;
        if ({carry_out, sum_out} !== exp_v) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%b actual %h expected %h",
                     req, a, b, cin, {carry_out, sum_out}, exp_v);
        end
    endtask

    task automatic t_zero();
        apply_check(16'h0000, 16'h0000, 1'b0, "R7");
    endtask

    task automatic t_carry_in();
        apply_check(16'h0000, 16'h0000, 1'b1, "R3");
        apply_check(16'h1234, 16'h4321, 1'b1, "R3");
        apply_check(16'h00FF, 16'h0000, 1'b1, "R3");
    endtask

    task automatic t_full_propagate();
        apply_check(16'hFFFF, 16'h0000, 1'b0, "R4");
        apply_check(16'hFFFF, 16'h0000, 1'b1, "R4");
        apply_check(16'hA5A5, 16'h5A5A, 1'b1, "R4");
        apply_check(16'h0F0F, 16'hF0F0, 1'b1, "R4");
    endtask

    task automatic t_slice_generate();
        for (int k = 0; k < 4; k++) begin
            apply_check(16'(16'h000F << (4*k)), 16'(16'h0001 << (4*k)), 1'b0, "R5");
        end
        apply_check(16'hFFF0, 16'h0010, 1'b0, "R5");
        apply_check(16'h0880, 16'h0780, 1'b0, "R5");
    endtask

    task automatic t_overflow_edges();
        apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R2");
        apply_check(16'hFFFF, 16'hFFFF, 1'b0, "R2");
        apply_check(16'h8000, 16'h8000, 1'b0, "R2");
        apply_check(16'h7FFF, 16'h0001, 1'b0, "R2");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                for (int c = 0; c < 2; c++) begin
                    apply_check(16'(i * 16'h0407 + (i << 10)),
                                16'(j * 16'h0B13 ^ (j << 9)),
                                c[0], "R1");
                end
            end
        end
    endtask

    initial begin
        t_zero();
        t_carry_in();
        t_full_propagate();
        t_slice_generate();
        t_overflow_edges();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule